// File: doc/BRIEF.md
# Serial EEPROM Command Engine

This block is the host side of a three-wire serial link to a 64-word by 16-bit electrically erasable memory. A client presents one request at a time: a command code, a word address, a write word and a burst length. The engine turns the request into a serial transaction. It drives a serial clock derived from the system clock, a chip-select line and a data line toward the memory, and it samples the memory's data line back.

Each transaction opens with a one-bit start marker. A two-bit operation field and a six-bit address field follow, and a sixteen-bit data field comes last when the command carries data. A read keeps chip select high long enough to pull in a burst of consecutive words. The memory's own address increment supplies the burst, and the engine throws away the leading zero that the memory inserts before the first word. The program commands are word write, whole-array write, word erase and whole-array erase. For these the engine closes the frame and lets chip select rest low. It then raises chip select again without clocking and watches the return line until the memory reports that it is idle. It gives up with a timeout flag if that does not happen in time.

Serial clock high time, serial clock low time, minimum chip-select rest, status settling delay and the poll limit are all counted in system clock cycles and set by parameters.

Top module: `mwh_host`

## Requirements
- R1: While reset is held and after it is released, ser_sel, ser_clk, ser_out, busy, done, rd_valid and timeout are all 0 until a request is accepted.
- R2: A frame is sent most significant bit first: start bit 1, then the 2-bit operation field, then the 6-bit address field, then 16 data bits for commands that carry data. ser_out changes only when ser_clk falls or when a transaction opens, and it stays stable while ser_clk is high. ser_clk stays high for SCK_HI cycles and low for SCK_LO cycles.
- R3: req_op selects the frame. 0 = read (field 10, address). 1 = word write (01, address, data). 2 = word erase (11, address). 3 = write enable (00, address field 110000). 4 = write disable (00, 000000). 5 = array write (00, 010000, data). 6 = array erase (00, 100000). Code 7 is sent as write disable.
- R4: A read lasts 9 + 16*(req_len+1) clocks under one chip select. The bit returned during the last address clock (the leading zero) is discarded. The bits returned in the following clocks are packed into req_len+1 words, most significant bit first, and each word is sampled one system clock before its falling serial edge. Each word is presented on rd_data with a one-cycle rd_valid pulse. Word k carries address (req_addr+k) mod 64.
- R5: For every command, ser_sel falls in the same cycle as the falling edge of the last frame clock, so no further rising serial edge occurs in that transaction.
- R6: After a program command (codes 1, 2, 5, 6), ser_sel stays low for CS_GAP cycles. It is then raised with ser_clk and ser_out held at 0. After STATUS_DLY cycles ser_in is sampled every cycle, and the first 1 seen ends the command. No new frame starts while the memory reports busy.
- R7: Every transaction ends with ser_sel low for at least CS_GAP cycles before done and before the next start bit.
- R8: If no 1 is seen within POLL_LIMIT polling cycles, timeout rises together with done and stays high until the next request is accepted.
- R9: busy rises in the cycle after a request is accepted and falls with done. A req_valid seen while busy is ignored.
- R10: done is a single-cycle pulse, one per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_op | input | 3 | Command code (see R3) |
| req_addr | input | 6 | Word address |
| req_wdata | input | 16 | Word for word write and array write |
| req_len | input | 6 | Read burst length minus one |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when a command ends |
| timeout | output | 1 | Last program command never reported ready |
| rd_valid | output | 1 | One-cycle strobe for each read word |
| rd_data | output | 16 | Read word |
| ser_clk | output | 1 | Serial clock to the memory |
| ser_sel | output | 1 | Chip select to the memory, active high |
| ser_out | output | 1 | Serial data to the memory |
| ser_in | input | 1 | Serial data from the memory |

## Verification
The bench attaches a cycle-level memory model. The model decodes the frames it receives, enforces the write-enable latch, models a programming delay and checks every serial high time, low time and chip-select rest. A word write followed by a single-word read shows whether frame bits, bit order and dummy-bit discard are right. A four-word burst from address 62 shows the word count and the address wrap. Array write, array erase, word erase, write disable and code 7 each leave a memory image that only the correct frame produces. A request made while busy, a write whose memory never becomes ready, and the run of polls after every program command separate request blocking, timeout handling and ready polling from the plain frame path.

// File: rtl/mwh_pkg.sv
package mwh_pkg;

  typedef enum logic [2:0] {
    CMD_READ  = 3'd0,
    CMD_WRITE = 3'd1,
    CMD_ERASE = 3'd2,
    CMD_WREN  = 3'd3,
    CMD_WRDIS = 3'd4,
    CMD_FILL  = 3'd5,
    CMD_CLEAR = 3'd6
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_LOW  = 3'd1,
    S_HIGH = 3'd2,
    S_GAP  = 3'd3,
    S_POLL = 3'd4,
    S_END  = 3'd5
  } seq_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mwh_timer.sv
// Shared phase timer: a load of N makes last rise in the Nth cycle after load.
module mwh_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          last
);
  logic [TW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load)                cnt_n = val - TW'(1);
    else if (cnt_q != '0)    cnt_n = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/mwh_frame.sv
// Builds the left-aligned serial frame for one command.
module mwh_frame import mwh_pkg::*; #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int FW = 3 + AW + DW
) (
  input  cmd_e          cmd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [FW-1:0] frame,
  output logic          has_data,
  output logic          is_read,
  output logic          is_prog
);
  logic [1:0]    op;
  logic [AW-1:0] afield;

  always_comb begin
    op       = 2'b00;
    afield   = addr;
    has_data = 1'b0;
    is_read  = 1'b0;
    is_prog  = 1'b0;
    case (cmd)
      CMD_READ:  begin op = 2'b10; is_read = 1'b1; end
      CMD_WRITE: begin op = 2'b01; has_data = 1'b1; is_prog = 1'b1; end
      CMD_ERASE: begin op = 2'b11; is_prog = 1'b1; end
      CMD_WREN:  afield = {2'b11, {(AW-2){1'b0}}};
      CMD_FILL:  begin afield = {2'b01, {(AW-2){1'b0}}}; has_data = 1'b1; is_prog = 1'b1; end
      CMD_CLEAR: begin afield = {2'b10, {(AW-2){1'b0}}}; is_prog = 1'b1; end
      default:   afield = '0;
    endcase
    frame = {1'b1, op, afield, (has_data ? wdata : {DW{1'b0}})};
  end
endmodule

// File: rtl/mwh_rx.sv
// Packs sampled return bits into words, MSB first.
module mwh_rx #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          sample,
  input  logic          bit_in,
  output logic          word_valid,
  output logic [DW-1:0] word
);
  localparam int BW = $clog2(DW);

  logic [DW-1:0] sh_q, sh_n, word_q, word_n;
  logic [BW-1:0] cnt_q, cnt_n;
  logic          vld_q, vld_n;

  always_comb begin
    sh_n   = sh_q;
    cnt_n  = cnt_q;
    word_n = word_q;
    vld_n  = 1'b0;
    if (clr) begin
      cnt_n = '0;
    end else if (sample) begin
      sh_n = {sh_q[DW-2:0], bit_in};
      if (cnt_q == BW'(DW-1)) begin
        cnt_n  = '0;
        vld_n  = 1'b1;
        word_n = sh_n;
      end else begin
        cnt_n = cnt_q + BW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      sh_q   <= sh_n;
      cnt_q  <= cnt_n;
      word_q <= word_n;
      vld_q  <= vld_n;
    end
  end

  assign word_valid = vld_q;
  assign word       = word_q;
endmodule

// File: rtl/mwh_host.sv
// Host engine for a 64x16 three-wire serial EEPROM. rst_n is expected to be
// asserted asynchronously and released in step with clk by the reset tree.
module mwh_host import mwh_pkg::*; #(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int SCK_HI     = 50,
  parameter int SCK_LO     = 50,
  parameter int CS_GAP     = 50,
  parameter int STATUS_DLY = 50,
  parameter int POLL_LIMIT = 2000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [ADDR_W-1:0] req_len,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              ser_clk,
  output logic              ser_sel,
  output logic              ser_out,
  input  logic              ser_in
);
  localparam int HDR_W = 3 + ADDR_W;
  localparam int FW    = HDR_W + DATA_W;
  localparam int CW    = $clog2(HDR_W + DATA_W * (2 ** ADDR_W) + 1);
  localparam int TW    = $clog2(imax(imax(SCK_HI, SCK_LO), CS_GAP) + 1);
  localparam int PW    = $clog2(POLL_LIMIT + 1);

  seq_e            st_q, st_n;
  logic [FW-1:0]   frm_q, frm_n, frm_new;
  logic [CW-1:0]   idx_q, idx_n, tot_q, tot_n;
  logic [PW-1:0]   pc_q, pc_n;
  logic            rd_q, rd_n, prg_q, prg_n;
  logic            sel_q, sel_n, sck_q, sck_n;
  logic            done_q, done_n, to_q, to_n, fail_q, fail_n;
  logic            new_data, new_rd, new_prg;
  logic            t_load, t_last;
  logic [TW-1:0]   t_val;
  logic            accept, sample;
  logic [CW-1:0]   frame_clks, read_clks;

  mwh_frame #(.AW(ADDR_W), .DW(DATA_W), .FW(FW)) u_frame (
    .cmd      (cmd_e'(req_op)),
    .addr     (req_addr),
    .wdata    (req_wdata),
    .frame    (frm_new),
    .has_data (new_data),
    .is_read  (new_rd),
    .is_prog  (new_prg)
  );

  mwh_timer #(.TW(TW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (t_load),
    .val   (t_val),
    .last  (t_last)
  );

  mwh_rx #(.DW(DATA_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (accept),
    .sample     (sample),
    .bit_in     (ser_in),
    .word_valid (rd_valid),
    .word       (rd_data)
  );

  assign frame_clks = new_data ? CW'(FW) : CW'(HDR_W);
  assign read_clks  = CW'(HDR_W) + CW'(DATA_W) * (CW'(req_len) + CW'(1));

  // Return bits count only after the header; the bit seen during the last
  // address clock is the leading zero and is skipped.
  assign sample = (st_q == S_HIGH) && t_last && rd_q && (idx_q >= CW'(HDR_W));

  always_comb begin
    st_n   = st_q;
    frm_n  = frm_q;
    idx_n  = idx_q;
    tot_n  = tot_q;
    pc_n   = pc_q;
    rd_n   = rd_q;
    prg_n  = prg_q;
    sel_n  = sel_q;
    sck_n  = sck_q;
    to_n   = to_q;
    fail_n = fail_q;
    done_n = 1'b0;
    t_load = 1'b0;
    t_val  = '0;
    accept = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          frm_n  = frm_new;
          rd_n   = new_rd;
          prg_n  = new_prg;
          tot_n  = new_rd ? read_clks : frame_clks;
          idx_n  = '0;
          to_n   = 1'b0;
          fail_n = 1'b0;
          sel_n  = 1'b1;
          t_load = 1'b1;
          t_val  = TW'(SCK_LO);
          st_n   = S_LOW;
        end
      end
      S_LOW: begin
        if (t_last) begin
          sck_n  = 1'b1;
          t_load = 1'b1;
          t_val  = TW'(SCK_HI);
          st_n   = S_HIGH;
        end
      end
      S_HIGH: begin
        if (t_last) begin
          sck_n  = 1'b0;
          t_load = 1'b1;
          if (idx_q == tot_q - CW'(1)) begin
            sel_n = 1'b0;
            frm_n = '0;
            t_val = TW'(CS_GAP);
            st_n  = prg_q ? S_GAP : S_END;
          end else begin
            idx_n = idx_q + CW'(1);
            frm_n = {frm_q[FW-2:0], 1'b0};
            t_val = TW'(SCK_LO);
            st_n  = S_LOW;
          end
        end
      end
      S_GAP: begin
        if (t_last) begin
          sel_n = 1'b1;
          pc_n  = '0;
          st_n  = S_POLL;
        end
      end
      S_POLL: begin
        pc_n = pc_q + PW'(1);
        if ((pc_q >= PW'(STATUS_DLY)) && ser_in) begin
          sel_n  = 1'b0;
          t_load = 1'b1;
          t_val  = TW'(CS_GAP);
          st_n   = S_END;
        end else if (pc_q == PW'(POLL_LIMIT - 1)) begin
          fail_n = 1'b1;
          sel_n  = 1'b0;
          t_load = 1'b1;
          t_val  = TW'(CS_GAP);
          st_n   = S_END;
        end
      end
      S_END: begin
        if (t_last) begin
          done_n = 1'b1;
          to_n   = fail_q;
          st_n   = S_IDLE;
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      frm_q  <= '0;
      idx_q  <= '0;
      tot_q  <= '0;
      pc_q   <= '0;
      rd_q   <= 1'b0;
      prg_q  <= 1'b0;
      sel_q  <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      to_q   <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      frm_q  <= frm_n;
      idx_q  <= idx_n;
      tot_q  <= tot_n;
      pc_q   <= pc_n;
      rd_q   <= rd_n;
      prg_q  <= prg_n;
      sel_q  <= sel_n;
      sck_q  <= sck_n;
      done_q <= done_n;
      to_q   <= to_n;
      fail_q <= fail_n;
    end
  end

  assign busy    = (st_q != S_IDLE);
  assign done    = done_q;
  assign timeout = to_q;
  assign ser_clk = sck_q;
  assign ser_sel = sel_q;
  assign ser_out = frm_q[FW-1];
endmodule

// File: rtl/mwh_host_chk.sv
module mwh_host_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic timeout,
  input logic rd_valid,
  input logic ser_clk,
  input logic ser_sel,
  input logic ser_out
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_sel && !ser_clk));

  assert_rise_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> ser_sel);

  assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_out));

  assert_read_in_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);

  assert_sel_fall_clk_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_sel) |-> !ser_clk);

  assert_timeout_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> done);

  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind mwh_host mwh_host_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done),
  .timeout   (timeout),
  .rd_valid  (rd_valid),
  .ser_clk   (ser_clk),
  .ser_sel   (ser_sel),
  .ser_out   (ser_out)
);

// File: tb/mwh_host_test.sv
`timescale 1ns/1ps
module mwh_host_test;
  localparam int HI = 4, LO = 3, GAP = 6, SDLY = 3, PLIM = 300, PROG = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [5:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [5:0]  req_len = '0;
  logic        busy, done, timeout, rd_valid, ser_clk, ser_sel, ser_out;
  logic [15:0] rd_data;
  logic        miso_r = 1'b0;

  mwh_host #(.SCK_HI(HI), .SCK_LO(LO), .CS_GAP(GAP), .STATUS_DLY(SDLY),
             .POLL_LIMIT(PLIM)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_len(req_len),
    .busy(busy), .done(done), .timeout(timeout), .rd_valid(rd_valid),
    .rd_data(rd_data), .ser_clk(ser_clk), .ser_sel(ser_sel),
    .ser_out(ser_out), .ser_in(miso_r));

  int checks = 0, fails = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] mem [64];
  logic [15:0] exp_mem [64];
  logic        exp_wen = 1'b0;
  logic [24:0] msh = '0;
  int          mcnt = 0, busy_cnt = 0, rbit = 15, trans = 0;
  logic        wen = 1'b0, stat_pend = 1'b0, stuck = 1'b0, rdmode = 1'b0;
  logic [5:0]  raddr = '0;
  logic        pk = 1'b0, pc = 1'b0;
  int          hi_run = 0, lo_run = 0, cslo_run = 1000;
  int          err_hi = 0, err_lo = 0, err_gap = 0, err_busy = 0;

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i]     = 16'(i * 16'h0101) ^ 16'h5A00;
      exp_mem[i] = 16'(i * 16'h0101) ^ 16'h5A00;
    end
  end

  task automatic commit();
    logic prog;
    prog = 1'b0;
    if (mcnt == 25 && msh[24] && msh[23:22] == 2'b01) begin
      prog = 1'b1;
      if (wen) mem[msh[21:16]] = msh[15:0];
    end
    if (mcnt == 25 && msh[24] && msh[23:22] == 2'b00 && msh[21:20] == 2'b01) begin
      prog = 1'b1;
      if (wen) for (int i = 0; i < 64; i++) mem[i] = msh[15:0];
    end
    if (mcnt == 9 && msh[8] && msh[7:6] == 2'b11) begin
      prog = 1'b1;
      if (wen) mem[msh[5:0]] = 16'hFFFF;
    end
    if (mcnt == 9 && msh[8] && msh[7:6] == 2'b00 && msh[5:4] == 2'b10) begin
      prog = 1'b1;
      if (wen) for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
    end
    if (prog) begin
      stat_pend = 1'b1;
      if (wen) busy_cnt = PROG;
    end
  endtask

  always @(negedge clk) begin
    if (busy_cnt > 0) busy_cnt--;
    if (!ser_sel) begin
      if (pc && mcnt > 0) begin trans++; commit(); end
      mcnt = 0; rdmode = 1'b0; miso_r = 1'b0; cslo_run++;
    end else begin
      if (!pc) begin
        if (cslo_run < GAP) err_gap++;
        cslo_run = 0; lo_run = 0;
      end
      if (ser_clk) begin
        if (!pk) begin
          if (lo_run != LO) err_lo++;
          if (mcnt == 0 && busy_cnt > 0) err_busy++;
          stat_pend = 1'b0;
          msh = {msh[23:0], ser_out};
          mcnt++;
          if (mcnt == 9) begin
            if (msh[8] && msh[7:6] == 2'b10) begin
              raddr = msh[5:0]; rbit = 15; rdmode = 1'b1; miso_r = 1'b0;
            end else if (msh[8] && msh[7:6] == 2'b00 && msh[5:4] == 2'b11) wen = 1'b1;
            else if (msh[8] && msh[7:6] == 2'b00 && msh[5:4] == 2'b00) wen = 1'b0;
          end else if (mcnt > 9 && rdmode) begin
            miso_r = mem[raddr][rbit];
            if (rbit == 0) begin rbit = 15; raddr = raddr + 6'd1; end
            else rbit--;
          end
          hi_run = 0;
        end
        hi_run++;
      end else begin
        if (pk) begin
          if (hi_run != HI) err_hi++;
          lo_run = 0;
        end
        lo_run++;
        if (mcnt == 0 && stat_pend) miso_r = (busy_cnt > 0 || stuck) ? 1'b0 : 1'b1;
      end
    end
    pk = ser_clk;
    pc = ser_sel;
  end

  // ---------------- read capture ----------------
  logic [15:0] rxbuf [64];
  int rxn = 0;
  always @(negedge clk) if (rd_valid) begin
    if (rxn < 64) rxbuf[rxn] = rd_data;
    rxn++;
  end

  // ---------------- command tasks ----------------
  int   ncyc = 0, last_bz = 0;
  logic last_to = 1'b0;

  task automatic run_cmd(input logic [2:0] op, input logic [5:0] a,
                         input logic [15:0] d, input logic [5:0] len);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d; req_len = len;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 busy after accept", 32'(busy), 32'd1);
    ncyc = 1;
    while (!done) begin @(negedge clk); ncyc++; end
    last_to = timeout;
    last_bz = busy_cnt;
    chk("R9 busy low at done", 32'(busy), 32'd0);
    @(negedge clk);
    chk("R10 done single pulse", 32'(done), 32'd0);
  endtask

  task automatic rd_words(input logic [5:0] a, input logic [5:0] len);
    rxn = 0;
    run_cmd(3'd0, a, 16'h0, len);
    chk("R4 word count", 32'(rxn), 32'(len) + 32'd1);
    for (int i = 0; i <= int'(len); i++)
      chk("R4 read word", 32'(rxbuf[i]), 32'(exp_mem[6'(int'(a) + i)]));
  endtask

  task automatic wr_word(input logic [5:0] a, input logic [15:0] d);
    run_cmd(3'd1, a, d, 6'd0);
    if (exp_wen) exp_mem[a] = d;
  endtask

  task automatic t_reset();
    chk("R1 ser_sel reset", 32'(ser_sel), 0);
    chk("R1 ser_clk reset", 32'(ser_clk), 0);
    chk("R1 ser_out reset", 32'(ser_out), 0);
    chk("R1 busy/done/rd_valid/timeout reset", {28'd0, busy, done, rd_valid, timeout}, 0);
  endtask

  task automatic t_write_read();
    run_cmd(3'd3, 6'd0, 16'h0, 6'd0); exp_wen = 1'b1;
    wr_word(6'd5, 16'hA5C3);
    chk("R6 ready seen before done", 32'(last_bz), 0);
    chk("R6 poll outlasted programming", 32'(ncyc > PROG), 1);
    chk("R8 no timeout on ready", 32'(last_to), 0);
    rd_words(6'd5, 6'd0);
  endtask

  task automatic t_burst_wrap();
    wr_word(6'd62, 16'h1111);
    wr_word(6'd63, 16'h2222);
    wr_word(6'd0,  16'h3333);
    wr_word(6'd1,  16'h4444);
    rd_words(6'd62, 6'd3);
  endtask

  task automatic t_erase();
    run_cmd(3'd2, 6'd63, 16'h0, 6'd0);
    exp_mem[63] = 16'hFFFF;
    rd_words(6'd62, 6'd1);   // R5 R3: erase frame of exactly 9 clocks
  endtask

  task automatic t_fill_clear();
    run_cmd(3'd5, 6'd0, 16'h1234, 6'd0);
    for (int i = 0; i < 64; i++) exp_mem[i] = 16'h1234;
    rd_words(6'd10, 6'd1);   // R3 array write
    rd_words(6'd40, 6'd0);
    run_cmd(3'd6, 6'd0, 16'h0, 6'd0);
    for (int i = 0; i < 64; i++) exp_mem[i] = 16'hFFFF;
    rd_words(6'd20, 6'd0);   // R3 array erase
  endtask

  task automatic t_protect();
    run_cmd(3'd4, 6'd0, 16'h0, 6'd0); exp_wen = 1'b0;
    wr_word(6'd3, 16'hBEEF);
    rd_words(6'd3, 6'd0);    // R3 write disable holds
    run_cmd(3'd3, 6'd0, 16'h0, 6'd0); exp_wen = 1'b1;
    run_cmd(3'd7, 6'd0, 16'h0, 6'd0); exp_wen = 1'b0;
    wr_word(6'd2, 16'hCAFE);
    rd_words(6'd2, 6'd1);    // R3 code 7 acts as write disable
    run_cmd(3'd3, 6'd0, 16'h0, 6'd0); exp_wen = 1'b1;
  endtask

  task automatic t_busy_ignore();
    int t0;
    t0 = trans;
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd1; req_addr = 6'd9; req_wdata = 16'h0F0F;
    @(negedge clk);
    req_op = 3'd6;
    repeat (6) @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    exp_mem[9] = 16'h0F0F;
    @(negedge clk);
    chk("R9 request during busy ignored", 32'(trans - t0), 1);
    rd_words(6'd8, 6'd1);
  endtask

  task automatic t_timeout();
    stuck = 1'b1;
    wr_word(6'd7, 16'h7777);
    chk("R8 timeout flag at done", 32'(last_to), 1);
    chk("R8 full poll window", 32'(ncyc >= PLIM), 1);
    stuck = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 timeout held while idle", 32'(timeout), 1);
    rd_words(6'd7, 6'd0);
    chk("R8 timeout cleared by next request", 32'(last_to), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write_read();
    t_burst_wrap();
    t_erase();
    t_fill_clear();
    t_protect();
    t_busy_ignore();
    t_timeout();
    chk("R2 serial high time", 32'(err_hi), 0);
    chk("R2 serial low time", 32'(err_lo), 0);
    chk("R7 chip select rest", 32'(err_gap), 0);
    chk("R6 no frame while busy", 32'(err_busy), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule